// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral supervises software by counting down from a programmed period and demanding a two-word service sequence late in each period. Software loads a 12-bit period value, picks how large the closing service window is, selects whether a fault should reset the system or raise a non-maskable interrupt, and then arms the timer with one 32-bit key. From then on the timer cannot be stopped or reconfigured short of a reset.

A service that completes while the remaining count is still above the window threshold is a fault. Letting the count run to zero is also a fault. Each fault raises a one-cycle pulse on the selected output and sets a sticky status flag that software clears by writing one to it. Every fault reloads the counter, and so does every legal service. The live count can be read back at any time.

The register bus is a single-cycle write strobe with a word index. Read data is a combinational function of the index.

Top module: `win_watchdog`

## Requirements
- R1: The timer stays idle with a count of 0 until the word 0xA98559DA is written to the control register (index 0). A write of any other value leaves it idle. While the timer runs, the control register reads 0xA98559DA; while it is idle, it reads 0.
- R2: On arming and on every reload, the counter (read at index 4) is loaded with the 12-bit period register (index 1, reset value 0xFFF) shifted left by 13. It then falls by one on each clock.
- R3: A service is the key register (index 3) receiving 0xE51A and then 0xA35C as consecutive key writes. Any other key word returns the sequence to its start without servicing. A lone 0xA35C does nothing.
- R4: The window register (index 6) accepts 0x50, 0x500, 0x5000, 0x50000 and 0x500000, which select an open window of 1/2, 1/4, 1/8, 1/16 and 1/32 of the period. It reads back the selected encoding. The window is open while the count is at or below the loaded period shifted right by 1, 2, 3, 4 or 5 places respectively.
- R5: A service that completes while the window is closed is a violation.
- R6: If the count is 0 on a clock edge and no legal service completes at that edge, a violation occurs.
- R7: If the low four bits of the reaction register (index 5) equal 0xA, violations pulse `nmi_o`. Otherwise they pulse `sys_rst_o`. The other output stays low.
- R8: Bit 1 of the status register (index 2) is set by every violation. It is cleared only by writing a word with bit 1 set, and it is unaffected by writes with bit 1 clear.
- R9: Once the timer runs, writes to the reaction and window registers are ignored. A write to the control register does not stop the counter.
- R10: A window write outside the five legal encodings selects the 1/2 window and reads back 0x50.
- R11: A violation output is high for exactly one cycle. The counter is reloaded at the same edge that raises it.
- R12: A legal service causes no violation and reloads the counter at the edge that accepts the second key word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected index |
| sys_rst_o | output | 1 | One-cycle reset request on a violation |
| nmi_o | output | 1 | One-cycle non-maskable interrupt on a violation |

## Verification
Every write takes effect at the rising edge that samples the strobe. The counter reload, the status flag and the violation pulse all appear right after that edge, and the pulse clears one edge later. The counter expires at the first edge after the count reads zero. The bench drives and reads only on falling edges. To probe the window edges exactly, it watches the count and drives the final key word while the count shows the target value, so the accepting edge sees precisely that value. It then samples the outputs at the next falling edge.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int NUM_WIN   = 5;
  localparam int WINK_W    = 3;

  localparam logic [DATA_W-1:0] ARM_WORD   = 32'hA985_59DA;
  localparam logic [DATA_W-1:0] SVC_FIRST  = 32'h0000_E51A;
  localparam logic [DATA_W-1:0] SVC_SECOND = 32'h0000_A35C;
  localparam logic [DATA_W-1:0] WIN_BASE   = 32'h0000_0050;
  localparam logic [DATA_W-1:0] WIN_UNIT   = 32'h0000_0005;
  localparam logic [3:0]        NMI_SEL    = 4'hA;
  localparam int                FLAG_BIT   = 1;

  typedef enum logic [ADDR_W-1:0] {
    IDX_ARM     = 3'd0,
    IDX_PERIOD  = 3'd1,
    IDX_STATUS  = 3'd2,
    IDX_KEY     = 3'd3,
    IDX_COUNT   = 3'd4,
    IDX_REACT   = 3'd5,
    IDX_WINDOW  = 3'd6
  } reg_idx_e;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_PRIMED = 1'b1
  } keyseq_e;
endpackage

// File: rtl/wdw_winsel.sv
module wdw_winsel
  import wdw_pkg::*;
(
  input  logic [DATA_W-1:0] wr_data,
  output logic [WINK_W-1:0] win_k
);
  logic [NUM_WIN-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN; gi++) begin : g_code
      assign hit[gi] = (wr_data == (WIN_BASE << (4 * gi)));
    end
  endgenerate

  always_comb begin
    win_k = WINK_W'(1);
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit[i]) win_k = WINK_W'(i + 1);
    end
  end

  always_comb begin
    AST_WIN_ONE_CODE: assert ($onehot0(hit)); // R4
  end
endmodule

// File: rtl/wdw_keyseq.sv
module wdw_keyseq
  import wdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              svc_done
);
  keyseq_e st_q, st_d;
  logic    st_en;

  always_comb begin
    st_d     = st_q;
    svc_done = 1'b0;
    st_en    = run && key_wr;
    if (st_en) begin
      unique case (st_q)
        KS_IDLE:   st_d = (key_data == SVC_FIRST) ? KS_PRIMED : KS_IDLE;
        KS_PRIMED: begin
          st_d     = KS_IDLE;
          svc_done = (key_data == SVC_SECOND);
        end
        default:   st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= KS_IDLE;
    else if (st_en) st_q <= st_d;
  end

  AST_KEY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> (st_q == KS_IDLE)); // R3
  AST_KEY_NEEDS_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |-> (st_q == KS_PRIMED)); // R3
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
  import wdw_pkg::*;
#(
  parameter int PRELOAD_W = 12,
  parameter int SHIFT     = 13,
  parameter int CNT_W     = PRELOAD_W + SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 reload,
  input  logic [PRELOAD_W-1:0] preload,
  input  logic [WINK_W-1:0]    win_k,
  output logic [CNT_W-1:0]     count,
  output logic                 win_open,
  output logic                 at_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, thresh;
  logic             cnt_en, per_en;

  always_comb begin
    per_d  = {preload, {SHIFT{1'b0}}};
    per_en = reload;
    cnt_en = reload || (run && (cnt_q != '0));
    cnt_d  = reload ? per_d : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_q <= '0;
    else if (per_en) per_q <= per_d;
  end

  assign thresh   = per_q >> win_k;
  assign win_open = run && (cnt_q <= thresh);
  assign at_zero  = run && (cnt_q == '0);
  assign count    = cnt_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !reload && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2
  AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == per_q)); // R12
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdw_pkg::*;
#(
  parameter int PRELOAD_W = 12,
  parameter int SHIFT     = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 sys_rst_o,
  output logic                 nmi_o
);
  localparam int CNT_W = PRELOAD_W + SHIFT;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // write decode
  logic wr_arm, wr_period, wr_status, wr_key, wr_react, wr_window;
  assign wr_arm    = bus_wr && (bus_addr == IDX_ARM);
  assign wr_period = bus_wr && (bus_addr == IDX_PERIOD);
  assign wr_status = bus_wr && (bus_addr == IDX_STATUS);
  assign wr_key    = bus_wr && (bus_addr == IDX_KEY);
  assign wr_react  = bus_wr && (bus_addr == IDX_REACT);
  assign wr_window = bus_wr && (bus_addr == IDX_WINDOW);

  // state
  logic                 run_q, run_d;
  logic [PRELOAD_W-1:0] period_q, period_d;
  logic [3:0]           react_q, react_d;
  logic [WINK_W-1:0]    wink_q, wink_d, wink_wr;
  logic                 flag_q, flag_d;
  logic                 rst_pulse_q, rst_pulse_d;
  logic                 nmi_pulse_q, nmi_pulse_d;
  logic                 cfg_en, flag_en;

  // datapath links
  logic             svc_done, win_open, at_zero;
  logic             start, svc_ok, svc_early, expire, viol, reload;
  logic [CNT_W-1:0] count;

  wdw_winsel u_winsel (
    .wr_data (bus_wdata),
    .win_k   (wink_wr)
  );

  wdw_keyseq u_keyseq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (run_q),
    .key_wr   (wr_key),
    .key_data (bus_wdata),
    .svc_done (svc_done)
  );

  wdw_counter #(
    .PRELOAD_W (PRELOAD_W),
    .SHIFT     (SHIFT),
    .CNT_W     (CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (run_q),
    .reload   (reload),
    .preload  (period_q),
    .win_k    (wink_q),
    .count    (count),
    .win_open (win_open),
    .at_zero  (at_zero)
  );

  // event logic
  always_comb begin
    start     = wr_arm && !run_q && (bus_wdata == ARM_WORD);
    svc_ok    = svc_done && win_open;
    svc_early = svc_done && !win_open;
    expire    = at_zero && !svc_ok;
    viol      = svc_early || expire;
    reload    = start || svc_ok || viol;
  end

  // next state
  always_comb begin
    cfg_en      = !run_q;
    run_d       = run_q || start;
    period_d    = wr_period ? bus_wdata[PRELOAD_W-1:0] : period_q;
    react_d     = (cfg_en && wr_react)  ? bus_wdata[3:0] : react_q;
    wink_d      = (cfg_en && wr_window) ? wink_wr        : wink_q;
    flag_en     = viol || (wr_status && bus_wdata[FLAG_BIT]);
    flag_d      = viol;
    rst_pulse_d = viol && (react_q != NMI_SEL);
    nmi_pulse_d = viol && (react_q == NMI_SEL);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      run_q    <= 1'b0;
      period_q <= '1;
      react_q  <= '0;
      wink_q   <= WINK_W'(1);
    end else begin
      run_q    <= run_d;
      period_q <= period_d;
      react_q  <= react_d;
      wink_q   <= wink_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rst_pulse_q <= 1'b0;
      nmi_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= rst_pulse_d;
      nmi_pulse_q <= nmi_pulse_d;
    end
  end

  assign sys_rst_o = rst_pulse_q;
  assign nmi_o     = nmi_pulse_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      IDX_ARM:    bus_rdata = run_q ? ARM_WORD : '0;
      IDX_PERIOD: bus_rdata = DATA_W'(period_q);
      IDX_STATUS: bus_rdata = DATA_W'({flag_q, 1'b0});
      IDX_COUNT:  bus_rdata = DATA_W'(count);
      IDX_REACT:  bus_rdata = DATA_W'(react_q);
      IDX_WINDOW: bus_rdata = WIN_UNIT << {wink_q, 2'b00};
      default:    bus_rdata = '0;
    endcase
  end

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    run_q |=> run_q); // R9
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_i_n)
    run_q |=> ($stable(react_q) && $stable(wink_q))); // R9
  AST_EARLY_FAULT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (svc_done && !win_open) |=> (sys_rst_o || nmi_o)); // R5
  AST_EXPIRE_FAULT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (at_zero && !svc_done) |=> (sys_rst_o || nmi_o)); // R6
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sys_rst_o || nmi_o) |-> flag_q); // R8
  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_i_n)
    sys_rst_o |-> (react_q != NMI_SEL)); // R7
  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_i_n)
    !run_q |=> !(sys_rst_o || nmi_o)); // R1
endmodule

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
  import wdw_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              sys_rst_o, nmi_o;

  int checks = 0;
  int errors = 0;
  localparam int PERIOD1 = 1 << 13;

  win_watchdog uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sys_rst_o (sys_rst_o),
    .nmi_o     (nmi_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    bus_wr = 1'b0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  // drive the second key word while the count shows target
  task automatic finish_at(input int target);
    logic [31:0] v;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      rd(IDX_COUNT, v);
      if (v == 32'(target)) break;
    end
    bus_wr = 1'b1; bus_addr = IDX_KEY; bus_wdata = SVC_SECOND;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(IDX_ARM, v);    chk("R1 idle ctrl", v, 0);
    rd(IDX_COUNT, v);  chk("R1 idle count", v, 0);
    rd(IDX_STATUS, v); chk("R8 reset status", v, 0);
    rd(IDX_PERIOD, v); chk("R2 reset period", v, 32'hFFF);
    rd(IDX_WINDOW, v); chk("R4 reset window", v, 32'h50);
    chk("R7 reset outputs", {30'b0, sys_rst_o, nmi_o}, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(IDX_PERIOD, 32'h1);
    wr(IDX_ARM, 32'h1234_5678);
    rd(IDX_ARM, v);   chk("R1 wrong key ctrl", v, 0);
    tick(3);
    rd(IDX_COUNT, v); chk("R1 wrong key count", v, 0);
    wr(IDX_ARM, ARM_WORD);
    rd(IDX_ARM, v);   chk("R1 armed ctrl", v, ARM_WORD);
    rd(IDX_COUNT, v); chk("R2 loaded count", v, PERIOD1);
    tick(10);
    rd(IDX_COUNT, v); chk("R2 decrement", v, PERIOD1 - 10);
  endtask

  task automatic t_lock();
    logic [31:0] v, c1;
    wr(IDX_REACT, 32'hA);
    rd(IDX_REACT, v);  chk("R9 react locked", v, 0);
    wr(IDX_WINDOW, 32'h500);
    rd(IDX_WINDOW, v); chk("R9 window locked", v, 32'h50);
    wr(IDX_ARM, 32'h0);
    rd(IDX_ARM, v);    chk("R9 ctrl still armed", v, ARM_WORD);
    rd(IDX_COUNT, c1);
    tick(1);
    rd(IDX_COUNT, v);  chk("R9 still counting", v, c1 - 1);
  endtask

  task automatic t_keyseq();
    logic [31:0] v;
    wr(IDX_KEY, SVC_SECOND);
    chk("R3 lone second word", {31'b0, sys_rst_o}, 0);
    wr(IDX_KEY, SVC_FIRST);
    wr(IDX_KEY, 32'h1234);
    wr(IDX_KEY, SVC_SECOND);
    chk("R3 broken sequence no pulse", {31'b0, sys_rst_o}, 0);
    rd(IDX_STATUS, v); chk("R3 broken sequence status", v, 0);
    rd(IDX_COUNT, v);  chk("R3 no reload", {31'b0, v < PERIOD1 - 20}, 1);
  endtask

  task automatic t_early();
    logic [31:0] v;
    wr(IDX_KEY, SVC_FIRST);
    wr(IDX_KEY, SVC_SECOND);
    chk("R5 early service pulse", {31'b0, sys_rst_o}, 1);
    chk("R7 no nmi", {31'b0, nmi_o}, 0);
    rd(IDX_STATUS, v); chk("R8 flag set", v, 2);
    rd(IDX_COUNT, v);  chk("R11 reload on fault", v, PERIOD1);
    tick(1);
    chk("R11 one cycle pulse", {31'b0, sys_rst_o}, 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(IDX_STATUS, 32'h0);
    rd(IDX_STATUS, v); chk("R8 zero write keeps flag", v, 2);
    wr(IDX_STATUS, 32'h2);
    rd(IDX_STATUS, v); chk("R8 w1 clears", v, 0);
  endtask

  task automatic t_window(input int thr, input logic use_nmi, input string req);
    logic [31:0] v;
    wr(IDX_KEY, SVC_FIRST);
    finish_at(thr);
    chk({req, " edge service legal"}, {30'b0, sys_rst_o, nmi_o}, 0);
    rd(IDX_COUNT, v); chk("R12 service reloads", v, PERIOD1);
    wr(IDX_KEY, SVC_FIRST);
    finish_at(thr + 1);
    chk({req, " one above edge faults"}, {30'b0, sys_rst_o, nmi_o},
        use_nmi ? 32'd1 : 32'd2);
    tick(1);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    wr(IDX_STATUS, 32'h2);
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      rd(IDX_COUNT, v);
      if (v == 0) break;
    end
    chk("R6 no pulse at zero yet", {31'b0, sys_rst_o}, 0);
    tick(1);
    chk("R6 expiry pulse", {31'b0, sys_rst_o}, 1);
    rd(IDX_COUNT, v);  chk("R11 reload after expiry", v, PERIOD1);
    rd(IDX_STATUS, v); chk("R8 flag after expiry", v, 2);
    tick(1);
    chk("R11 expiry pulse ends", {31'b0, sys_rst_o}, 0);
  endtask

  task automatic t_nmi_quarter();
    logic [31:0] v;
    do_reset();
    wr(IDX_REACT, 32'hA);
    wr(IDX_WINDOW, 32'h500);
    wr(IDX_PERIOD, 32'h1);
    rd(IDX_REACT, v);  chk("R7 react readback", v, 32'hA);
    rd(IDX_WINDOW, v); chk("R4 quarter readback", v, 32'h500);
    wr(IDX_ARM, ARM_WORD);
    t_window(PERIOD1 / 4, 1'b1, "R4 R7 quarter nmi");
  endtask

  task automatic t_illegal_window();
    logic [31:0] v;
    do_reset();
    wr(IDX_WINDOW, 32'h500000);
    rd(IDX_WINDOW, v); chk("R4 smallest window readback", v, 32'h500000);
    wr(IDX_WINDOW, 32'h123);
    rd(IDX_WINDOW, v); chk("R10 illegal reads half", v, 32'h50);
    wr(IDX_PERIOD, 32'h1);
    wr(IDX_ARM, ARM_WORD);
    t_window(PERIOD1 / 2, 1'b0, "R10 illegal acts as half");
  endtask

  initial begin
    t_reset_state();
    t_enable();
    t_lock();
    t_keyseq();
    t_early();
    t_clear();
    wr(IDX_STATUS, 32'h2);
    t_window(PERIOD1 / 2, 1'b0, "R4 half window");
    t_expire();
    t_nmi_quarter();
    t_illegal_window();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog R1-R12 run actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule